// File: doc/BRIEF.md
# Bus Interrupt Forwarding Controller

This block gathers the seven active-low interrupt request levels of a backplane bus and turns them into one active-high host interrupt. Every level can be blocked by its own mask bit. Forwarding is off until software arms it. When an unmasked request is seen while the block is armed, it latches the highest active level, raises the host interrupt and disarms itself in the same clock edge. No further request reaches the host until software arms the block again.

Software clears the host interrupt by reading the pending level or by arming again. To fetch the interrupt vector, it asks for an acknowledge cycle on a chosen level. The sequencer drives the level onto the bus address lines and asserts the address strobe. It waits for the data acknowledge, latches the 8-bit vector and releases the strobe. Because some interrupters keep their request active after the acknowledge and only drop it on a later register access, the acknowledge cycle leaves the interrupt state untouched. Arming again while such a request is still active raises the host interrupt again.

Top module: `irq_forward_ctrl`

## Requirements
- R1: After reset, host_irq is 0, pend_level is 0, iack_as, iack_busy and vec_valid are 0, every level is masked and forwarding is disarmed.
- R2: mask_data bit i set to 1 blocks level i+1 (bit 0 is level 1, bit 6 is level 7). A masked level never raises host_irq. A mask_wr pulse loads the whole mask.
- R3: While disarmed, no request raises host_irq.
- R4: With the block armed, a level held low (and unmasked) from before rising edge k gives host_irq = 1 after edge k+2 and not earlier. pend_level is loaded on the same edge.
- R5: When several unmasked levels are active together, pend_level holds the highest level number, coded 1 to 7 in binary.
- R6: The edge that raises host_irq also disarms forwarding. Later requests raise nothing until an arm_wr pulse.
- R7: A stat_rd pulse or an arm_wr pulse clears host_irq on the following edge. pend_level keeps its value.
- R8: An arm_wr pulse while an unmasked request is still active raises host_irq again one edge after the arming edge.
- R9: An ack_req pulse seen while idle starts a cycle. After the next edge iack_busy is 1, iack_addr holds ack_level and iack_as is 0. After the edge that follows, iack_as is 1 and stays 1 until bus_dtack is sampled high. On that edge iack_as drops, vec_out takes bus_data and vec_valid is 1 for one cycle. iack_busy returns to 0 on the first edge with bus_dtack low.
- R10: An acknowledge cycle does not change host_irq, pend_level or the armed state.
- R11: ack_req is ignored while a cycle is in progress, and iack_addr keeps the level the cycle started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_irq_n | input | 7 | Interrupt request levels 1..7 (bit 0 = level 1), active low, asynchronous |
| mask_wr | input | 1 | Load the mask from mask_data |
| mask_data | input | 7 | New mask, 1 blocks the level |
| arm_wr | input | 1 | Arm forwarding and clear host_irq |
| stat_rd | input | 1 | Pending-status read strobe, clears host_irq |
| host_irq | output | 1 | Host interrupt, active high |
| pend_level | output | 3 | Level latched at detection, 0 = none since reset |
| ack_req | input | 1 | Start an acknowledge cycle |
| ack_level | input | 3 | Level to acknowledge (1..7) |
| bus_dtack | input | 1 | Data acknowledge from the interrupter, active high |
| bus_data | input | 8 | Vector presented by the interrupter |
| iack_as | output | 1 | Acknowledge address strobe, active high |
| iack_addr | output | 3 | Level presented on the address lines, 0 when idle |
| iack_busy | output | 1 | Acknowledge cycle in progress |
| vec_out | output | 8 | Last captured vector |
| vec_valid | output | 1 | One-cycle pulse when vec_out is loaded |

## Verification
The assertions assume that arm_wr and stat_rd are never pulsed on an edge where an armed, unmasked request is detected. They also assume that bus_dtack and bus_data are synchronous to clk, that bus_dtack rises only while the strobe is out, and that it falls again before a new cycle begins. The bench drives every input on the falling edge. It pulses arm_wr and stat_rd only when no detection can be pending, and it raises bus_dtack only after it has seen iack_as high.

// File: rtl/irqfwd_pkg.sv
// irqfwd_pkg: shared types for the interrupt forwarding controller.
// Assumes: nothing; holds only the acknowledge sequencer state encoding.
package irqfwd_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE    = 2'd0,
        ACK_SETUP   = 2'd1,
        ACK_STROBE  = 2'd2,
        ACK_RELEASE = 2'd3
    } ack_state_t;

endpackage

// File: rtl/irqfwd_sync.sv
// irqfwd_sync: multi-stage synchronizer for active-low request lines.
// Output is active high. Flops reset to the inactive (high) level.
// Assumes: the inputs are level signals held longer than STAGES cycles.
module irqfwd_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_n,
    output logic [W-1:0] out_act
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    // Shift the raw levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q[0] <= in_n;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign out_act = ~pipe_q[STAGES-1];
endmodule

// File: rtl/irqfwd_detect.sv
// irqfwd_detect: mask register, arm flag, priority pick and host interrupt.
// Detection is level sensitive. A hit while armed latches the highest level,
// raises host_irq and disarms on the same edge.
// Assumes: req_act is already synchronous to clk.
module irqfwd_detect #(
    parameter int LEVELS = 7,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] req_act,
    input  logic              mask_wr,
    input  logic [LEVELS-1:0] mask_data,
    input  logic              arm_wr,
    input  logic              stat_rd,
    output logic [LEVELS-1:0] hit,
    output logic              armed,
    output logic              host_irq,
    output logic [LVL_W-1:0]  pend_level
);
    logic [LEVELS-1:0] mask_q;
    logic [LVL_W-1:0]  top_lvl;
    logic              detect;

    assign hit    = req_act & ~mask_q;
    assign detect = armed && (|hit);

    // Pick the highest numbered active level (1-based code).
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (hit[i]) top_lvl = LVL_W'(i + 1);
        end
    end

    // Hold the mask register; all levels blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= mask_data;
    end

    // Arm flag, host interrupt and latched level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            host_irq   <= 1'b0;
            pend_level <= '0;
        end else if (detect) begin
            armed      <= 1'b0;
            host_irq   <= 1'b1;
            pend_level <= top_lvl;
        end else if (arm_wr) begin
            armed      <= 1'b1;
            host_irq   <= 1'b0;
        end else if (stat_rd) begin
            host_irq   <= 1'b0;
        end
    end
endmodule

// File: rtl/irqfwd_ack.sv
// irqfwd_ack: acknowledge cycle sequencer.
// Drives the level onto the address lines, then the strobe. It latches the
// vector on data acknowledge and waits for the acknowledge to fall.
// Assumes: bus_dtack and bus_data are synchronous to clk.
module irqfwd_ack
    import irqfwd_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_req,
    input  logic [LVL_W-1:0] ack_level,
    input  logic             bus_dtack,
    input  logic [VEC_W-1:0] bus_data,
    output logic             iack_as,
    output logic [LVL_W-1:0] iack_addr,
    output logic             iack_busy,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    ack_state_t       state_q;
    logic [LVL_W-1:0] lvl_q;

    // Step the acknowledge cycle and capture the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ACK_IDLE;
            lvl_q     <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= 1'b0;
            case (state_q)
                ACK_IDLE: if (ack_req) begin
                    lvl_q   <= ack_level;
                    state_q <= ACK_SETUP;
                end
                ACK_SETUP: state_q <= ACK_STROBE;
                ACK_STROBE: if (bus_dtack) begin
                    vec_out   <= bus_data;
                    vec_valid <= 1'b1;
                    state_q   <= ACK_RELEASE;
                end
                ACK_RELEASE: if (!bus_dtack) state_q <= ACK_IDLE;
                default: state_q <= ACK_IDLE;
            endcase
        end
    end

    assign iack_as   = (state_q == ACK_STROBE);
    assign iack_busy = (state_q != ACK_IDLE);
    assign iack_addr = iack_busy ? lvl_q : '0;
endmodule

// File: rtl/irq_forward_ctrl.sv
// irq_forward_ctrl: forwards seven active-low bus interrupt levels to one
// host interrupt, with per-level mask, one-shot arming and an acknowledge
// cycle sequencer that fetches the vector.
// Assumes: bus_irq_n is asynchronous; every other input is synchronous to clk.
module irq_forward_ctrl #(
    parameter int LEVELS  = 7,
    parameter int STAGES  = 2,
    parameter int VEC_W   = 8,
    localparam int LVL_W  = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] bus_irq_n,
    input  logic              mask_wr,
    input  logic [LEVELS-1:0] mask_data,
    input  logic              arm_wr,
    input  logic              stat_rd,
    output logic              host_irq,
    output logic [LVL_W-1:0]  pend_level,
    input  logic              ack_req,
    input  logic [LVL_W-1:0]  ack_level,
    input  logic              bus_dtack,
    input  logic [VEC_W-1:0]  bus_data,
    output logic              iack_as,
    output logic [LVL_W-1:0]  iack_addr,
    output logic              iack_busy,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid
);
    logic [LEVELS-1:0] req_act;
    logic [LEVELS-1:0] hit_vec;
    logic              armed_q;

    irqfwd_sync #(.W(LEVELS), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_n    (bus_irq_n),
        .out_act (req_act)
    );

    irqfwd_detect #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_act    (req_act),
        .mask_wr    (mask_wr),
        .mask_data  (mask_data),
        .arm_wr     (arm_wr),
        .stat_rd    (stat_rd),
        .hit        (hit_vec),
        .armed      (armed_q),
        .host_irq   (host_irq),
        .pend_level (pend_level)
    );

    irqfwd_ack #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_req   (ack_req),
        .ack_level (ack_level),
        .bus_dtack (bus_dtack),
        .bus_data  (bus_data),
        .iack_as   (iack_as),
        .iack_addr (iack_addr),
        .iack_busy (iack_busy),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );
endmodule

// File: rtl/irqfwd_checker.sv
// irqfwd_checker: protocol properties of irq_forward_ctrl, bound to the top.
// Assumes: arm_wr and stat_rd never coincide with a detection edge.
module irqfwd_checker #(
    parameter int LEVELS = 7,
    parameter int LVL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEVELS-1:0] hit,
    input logic              armed,
    input logic              host_irq,
    input logic [LVL_W-1:0]  pend_level,
    input logic              arm_wr,
    input logic              stat_rd,
    input logic              iack_as,
    input logic              bus_dtack,
    input logic              vec_valid
);
    a_r3_raise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> $past(armed));

    a_r4_hit_raises_next: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (|hit)) |=> host_irq);

    a_r5_level_coded: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (pend_level != '0));

    a_r6_disarm_on_raise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> !armed);

    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && (stat_rd || arm_wr) && !(armed && (|hit))) |=> !host_irq);

    a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !stat_rd && !arm_wr) |=> host_irq);

    a_r9_strobe_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_as && !bus_dtack) |=> iack_as);

    a_r9_vec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
endmodule

bind irq_forward_ctrl irqfwd_checker #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit_vec),
    .armed      (armed_q),
    .host_irq   (host_irq),
    .pend_level (pend_level),
    .arm_wr     (arm_wr),
    .stat_rd    (stat_rd),
    .iack_as    (iack_as),
    .bus_dtack  (bus_dtack),
    .vec_valid  (vec_valid)
);

// File: tb/test_irq_forward_ctrl.sv
// test_irq_forward_ctrl: directed bench, one task per scenario.
// Inputs change on the falling edge; outputs are sampled on the falling edge.
module test_irq_forward_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] bus_irq_n;
    logic       mask_wr;
    logic [6:0] mask_data;
    logic       arm_wr;
    logic       stat_rd;
    logic       host_irq;
    logic [2:0] pend_level;
    logic       ack_req;
    logic [2:0] ack_level;
    logic       bus_dtack;
    logic [7:0] bus_data;
    logic       iack_as;
    logic [2:0] iack_addr;
    logic       iack_busy;
    logic [7:0] vec_out;
    logic       vec_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_forward_ctrl i_irq_forward_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_irq_n(bus_irq_n),
        .mask_wr(mask_wr), .mask_data(mask_data), .arm_wr(arm_wr),
        .stat_rd(stat_rd), .host_irq(host_irq), .pend_level(pend_level),
        .ack_req(ack_req), .ack_level(ack_level), .bus_dtack(bus_dtack),
        .bus_data(bus_data), .iack_as(iack_as), .iack_addr(iack_addr),
        .iack_busy(iack_busy), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mask(input logic [6:0] m);
        mask_data = m; mask_wr = 1'b1; cyc(1); mask_wr = 1'b0;
    endtask

    task automatic pulse_arm();
        arm_wr = 1'b1; cyc(1); arm_wr = 1'b0;
    endtask

    task automatic pulse_read();
        stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; bus_irq_n = '1; mask_wr = 0; mask_data = '0; arm_wr = 0;
        stat_rd = 0; ack_req = 0; ack_level = '0; bus_dtack = 0; bus_data = '0;
        cyc(3); rst_n = 1'b1; cyc(1);
        check("R1", "host_irq", host_irq, 0);
        check("R1", "pend_level", pend_level, 0);
        check("R1", "iack_as", iack_as, 0);
        check("R1", "iack_busy", iack_busy, 0);
        check("R1", "vec_valid", vec_valid, 0);
        // r1_ masked out of reset: arm and assert a level, nothing appears
        pulse_arm(); bus_irq_n = 7'b1111110; cyc(5);
        check("R1", "masked after reset", host_irq, 0);
        bus_irq_n = '1; cyc(3);
    endtask

    task automatic t_disarmed();
        // block is still armed from t_reset; clear arm by a detection is not
        // possible without an irq, so reset to get the disarmed state.
        rst_n = 1'b0; cyc(1); rst_n = 1'b1;
        write_mask('0);
        bus_irq_n = 7'b1111011; cyc(6);
        check("R3", "host_irq while disarmed", host_irq, 0);
        bus_irq_n = '1; cyc(3);
    endtask

    task automatic t_mask();
        write_mask(7'b1111101);          // only level 2 open
        pulse_arm();
        bus_irq_n = 7'b1101111;          // level 5 (masked)
        cyc(6);
        check("R2", "masked level 5", host_irq, 0);
        bus_irq_n = 7'b1101101;          // add level 2
        cyc(2);
        check("R4", "not before third edge", host_irq, 0);
        cyc(1);
        check("R4", "host_irq at third edge", host_irq, 1);
        check("R2", "pend_level unmasked level", pend_level, 2);
        bus_irq_n = '1;
        pulse_read();
        check("R7", "stat_rd clears host_irq", host_irq, 0);
        check("R7", "pend_level kept", pend_level, 2);
        cyc(3);
    endtask

    task automatic t_priority();
        write_mask('0);
        pulse_arm();
        bus_irq_n = 7'b1010110;          // levels 1, 4, 6
        cyc(2);
        check("R4", "latency lower bound", host_irq, 0);
        cyc(1);
        check("R4", "latency upper bound", host_irq, 1);
        check("R5", "highest level wins", pend_level, 6);
        pulse_read();
        check("R7", "read clears", host_irq, 0);
        cyc(5);
        check("R6", "disarmed with levels still active", host_irq, 0);
        bus_irq_n = 7'b0111111;          // level 7
        cyc(5);
        check("R6", "new level while disarmed", host_irq, 0);
        check("R6", "pend_level unchanged", pend_level, 6);
        arm_wr = 1'b1; cyc(1); arm_wr = 1'b0;
        check("R8", "not on arming edge", host_irq, 0);
        cyc(1);
        check("R8", "re-raise after arm", host_irq, 1);
        check("R8", "pend_level 7", pend_level, 7);
        bus_irq_n = '1; cyc(3);
        pulse_arm();
        check("R7", "arm_wr clears host_irq", host_irq, 0);
        cyc(2);
    endtask

    task automatic t_ack();
        // block armed, mask open; raise level 5 first
        bus_irq_n = 7'b1101111; cyc(3);
        check("R4", "level 5 raised", host_irq, 1);
        ack_level = 3'd5; ack_req = 1'b1; cyc(1); ack_req = 1'b0;
        check("R9", "busy after request", iack_busy, 1);
        check("R9", "addr shows level", iack_addr, 5);
        check("R9", "strobe not yet", iack_as, 0);
        cyc(1);
        check("R9", "strobe out", iack_as, 1);
        ack_level = 3'd2; ack_req = 1'b1; cyc(1); ack_req = 1'b0;
        check("R11", "addr kept during cycle", iack_addr, 5);
        cyc(1);
        check("R9", "strobe held awaiting dtack", iack_as, 1);
        bus_data = 8'hA5; bus_dtack = 1'b1; cyc(1);
        check("R9", "strobe released", iack_as, 0);
        check("R9", "vector captured", vec_out, 8'hA5);
        check("R9", "vec_valid pulse", vec_valid, 1);
        check("R9", "busy until dtack low", iack_busy, 1);
        cyc(1);
        check("R9", "still busy with dtack high", iack_busy, 1);
        check("R9", "vec_valid one cycle", vec_valid, 0);
        bus_dtack = 1'b0; cyc(1);
        check("R9", "idle after dtack low", iack_busy, 0);
        cyc(2);
        check("R11", "ignored request started nothing", iack_busy, 0);
        check("R10", "host_irq kept after ack", host_irq, 1);
        check("R10", "pend_level kept after ack", pend_level, 5);
        pulse_read();
        cyc(4);
        check("R10", "still disarmed, request active", host_irq, 0);
        bus_irq_n = '1; cyc(3);
    endtask

    task automatic t_ack_plain();
        ack_level = 3'd1; ack_req = 1'b1; cyc(1); ack_req = 1'b0;
        check("R9", "addr level 1", iack_addr, 1);
        cyc(1);
        bus_data = 8'h3C; bus_dtack = 1'b1; cyc(1); bus_dtack = 1'b0;
        check("R9", "vector 3C", vec_out, 8'h3C);
        cyc(1);
        check("R9", "idle", iack_busy, 0);
        check("R9", "addr idle zero", iack_addr, 0);
    endtask

    initial begin
        t_reset();
        t_disarmed();
        t_mask();
        t_priority();
        t_ack();
        t_ack_plain();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule